// File: doc/BRIEF.md
# Prescaled 16-bit Timer Counter

This block is a 16-bit counter driven by an incoming tick enable. The tick passes through a prescaler that can divide it by 1, 8, 32 or 128. A two-bit mode field selects one of four behaviours. The counter can be halted, run freely over the full 16-bit range, count up to a compare value and wrap, or count up to the compare value and back down to zero for centre-aligned waveforms. Each time the counter reaches its terminal value it sets a sticky overflow flag. When a mask bit is enabled, the flag drives an interrupt request.

Software uses an 8-bit register port with a registered read path. The count is read one byte at a time. A read of the low byte stores the high byte of that same count in a buffer. The following read of the high byte returns the buffered value, so the two bytes always belong to one count. A write of any value to the low-byte address clears the whole counter.

Register map (3-bit address):

| Address | Access | Contents |
|---------|--------|----------|
| 0 | read / write | count low byte on read; any write clears the counter |
| 1 | read | buffered high byte |
| 2 | read / write | control |
| 3 | read / write | compare value, low byte |
| 4 | read / write | compare value, high byte |

Control register fields:

| Bits | Field | Meaning |
|------|-------|---------|
| [1:0] | mode | 00 halt, 01 free-running, 10 modulo, 11 up/down |
| [3:2] | divider | 00 divide by 1, 01 by 8, 10 by 32, 11 by 128 |
| [4] | overflow flag | writing 0 clears it, writing 1 leaves it unchanged |
| [5] | interrupt mask | 1 enables the interrupt request |
| [7:6] | unused | read as 0 |

Top module: `tick_timer16`

## Requirements
- R1: The counter advances only on a prescaled step. One step occurs for every 1, 8, 32 or 128 asserted `tick_in` cycles, selected by control bits [3:2] with codes 00, 01, 10, 11. Without a step the count stays unchanged.
- R2: With mode 00 the count holds its present value, even while `tick_in` is asserted.
- R3: In free-running mode (01) the count increments by one per step and goes from 0xFFFF to 0x0000.
- R4: The overflow flag (control bit 4) is set by the step on which the counter reaches its terminal value. The terminal value is 0xFFFF in free-running mode, the compare value in modulo mode, and 0x0000 on the way down in up/down mode.
- R5: `irq` is high only while both the overflow flag and the mask bit (control bit 5) are 1.
- R6: A read of address 0 returns the low byte of the count at that moment and stores the high byte. A later read of address 1 returns the stored byte, even if the counter has moved on.
- R7: A write of any data to address 0 sets the count to 0x0000.
- R8: In modulo mode (10) the count rises from 0x0000 to the 16-bit compare value. The compare low byte is at address 3 and the high byte at address 4. On the next step the count returns to 0x0000.
- R9: In up/down mode (11) the count rises to the compare value and then falls to 0x0000, where it turns upward again.
- R10: The overflow flag stays set until a control write with bit 4 equal to 0. A control write with bit 4 equal to 1 leaves the flag unchanged. If an overflow and a clearing write happen in the same cycle, the flag ends up set.
- R11: A control write or a count clear restarts the prescaler. The first step after it comes only after a full divided period of ticks.
- R12: Reads return data one cycle after `bus_re`. The control register reads back as {2'b00, mask, flag, divider, mode}, and the compare bytes read back as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_in | input | 1 | Tick enable that feeds the prescaler |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered |
| irq | output | 1 | Interrupt request |

## Verification
The hardest condition to create from the ports is an overflow and a flag-clearing control write landing in the same clock cycle. The bench uses divide-by-1 and modulo mode, so every tick is a step. It brings the count to one below the compare value. It then asserts `tick_in` in exactly the cycle that carries the clearing write. The full free-running wrap also needs 65,535 steps. The bench holds `tick_in` high for that whole stretch and reads the count just before and just after 0xFFFF.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 3;
  localparam int DIV_W  = 7;

  typedef enum logic [1:0] {
    MODE_HALT = 2'd0,
    MODE_FREE = 2'd1,
    MODE_MOD  = 2'd2,
    MODE_UPDN = 2'd3
  } tmr_mode_e;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd3;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd4;

  localparam int CTRL_FLAG_BIT = 4;
  localparam int CTRL_MASK_BIT = 5;

  // log2 of the division ratio for each divider code
  function automatic int unsigned div_shift(input logic [1:0] code);
    case (code)
      2'd0:    return 0;
      2'd1:    return 3;
      2'd2:    return 5;
      default: return 7;
    endcase
  endfunction
endpackage

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PW = DIV_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_in,
  input  logic [1:0] div_code,
  input  logic       restart,
  output logic       step
);
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] lim;

  always_comb begin
    lim  = PW'((32'd1 << div_shift(div_code)) - 32'd1);
    step = tick_in && (cnt_q >= lim);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q <= '0;
    end else if (tick_in) begin
      if (cnt_q >= lim) cnt_q <= '0;
      else              cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core
  import tmr_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  tmr_mode_e     mode,
  input  logic [W-1:0]  cmp,
  input  logic          clr,
  input  logic          flag_clr,
  output logic [W-1:0]  cnt,
  output logic          flag
);
  logic [W-1:0] cnt_q, nxt;
  logic         down_q, down_n;
  logic         hit;
  logic         flag_q;

  always_comb begin
    nxt    = cnt_q;
    down_n = down_q;
    hit    = 1'b0;
    if (mode != MODE_UPDN) down_n = 1'b0;
    if (step) begin
      case (mode)
        MODE_FREE: begin
          nxt = cnt_q + 1'b1;
          hit = &nxt;
        end
        MODE_MOD: begin
          nxt = (cnt_q >= cmp) ? '0 : cnt_q + 1'b1;
          hit = (nxt == cmp);
        end
        MODE_UPDN: begin
          if (!down_q) begin
            if (cnt_q >= cmp) begin
              if (cnt_q != '0) begin
                nxt    = cnt_q - 1'b1;
                down_n = 1'b1;
                hit    = (nxt == '0);
              end
            end else begin
              nxt = cnt_q + 1'b1;
            end
          end else if (cnt_q == '0) begin
            nxt    = cnt_q + 1'b1;
            down_n = 1'b0;
          end else begin
            nxt = cnt_q - 1'b1;
            hit = (nxt == '0);
          end
          if (nxt == '0) down_n = 1'b0;
        end
        default: nxt = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else begin
      cnt_q  <= nxt;
      down_q <= down_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 flag_q <= 1'b0;
    else if (hit && !clr)    flag_q <= 1'b1;
    else if (flag_clr)       flag_q <= 1'b0;
  end

  assign cnt  = cnt_q;
  assign flag = flag_q;
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              flag,
  output logic [BYTE_W-1:0] rdata,
  output tmr_mode_e         mode,
  output logic [1:0]        div_code,
  output logic              mask,
  output logic [CNT_W-1:0]  cmp,
  output logic              cnt_clr,
  output logic              flag_clr,
  output logic              div_restart
);
  logic              ctrl_wr;
  logic [BYTE_W-1:0] hi_buf;

  always_comb begin
    ctrl_wr     = we && (addr == A_CTRL);
    cnt_clr     = we && (addr == A_CNT_LO);
    flag_clr    = ctrl_wr && !wdata[CTRL_FLAG_BIT];
    div_restart = ctrl_wr || cnt_clr;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= MODE_HALT;
      div_code <= 2'd0;
      mask     <= 1'b0;
      cmp      <= '0;
    end else if (we) begin
      case (addr)
        A_CTRL: begin
          mode     <= tmr_mode_e'(wdata[1:0]);
          div_code <= wdata[3:2];
          mask     <= wdata[CTRL_MASK_BIT];
        end
        A_CMP_LO: cmp[BYTE_W-1:0]     <= wdata;
        A_CMP_HI: cmp[CNT_W-1:BYTE_W] <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      hi_buf <= '0;
    end else if (re) begin
      case (addr)
        A_CNT_LO: begin
          rdata  <= cnt[BYTE_W-1:0];
          hi_buf <= cnt[CNT_W-1:BYTE_W];
        end
        A_CNT_HI: rdata <= hi_buf;
        A_CTRL:   rdata <= {2'b00, mask, flag, div_code, mode};
        A_CMP_LO: rdata <= cmp[BYTE_W-1:0];
        A_CMP_HI: rdata <= cmp[CNT_W-1:BYTE_W];
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tick_timer16.sv
module tick_timer16
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_in,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  output logic              irq
);
  tmr_mode_e        mode_w;
  logic [1:0]       div_w;
  logic             mask_w;
  logic [CNT_W-1:0] cmp_w;
  logic [CNT_W-1:0] cnt_w;
  logic             flag_w;
  logic             step_w;
  logic             clr_w, fclr_w, restart_w;

  tmr_regs u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .re(bus_re), .addr(bus_addr),
    .wdata(bus_wdata), .cnt(cnt_w), .flag(flag_w), .rdata(bus_rdata),
    .mode(mode_w), .div_code(div_w), .mask(mask_w), .cmp(cmp_w),
    .cnt_clr(clr_w), .flag_clr(fclr_w), .div_restart(restart_w)
  );

  tmr_prescale #(.PW(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .tick_in(tick_in), .div_code(div_w),
    .restart(restart_w), .step(step_w)
  );

  tmr_core #(.W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .step(step_w), .mode(mode_w), .cmp(cmp_w),
    .clr(clr_w), .flag_clr(fclr_w), .cnt(cnt_w), .flag(flag_w)
  );

  assign irq = flag_w && mask_w;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_we,
  input logic              bus_re,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic [BYTE_W-1:0] bus_rdata,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              flag,
  input logic              mask,
  input logic [1:0]        mode,
  input logic              step
);
  logic lo_wr, lo_rd, flag_wipe;
  assign lo_wr     = bus_we && (bus_addr == A_CNT_LO);
  assign lo_rd     = bus_re && (bus_addr == A_CNT_LO);
  assign flag_wipe = bus_we && (bus_addr == A_CTRL) && !bus_wdata[CTRL_FLAG_BIT];

  AST_NO_STEP_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!step && !lo_wr) |=> $stable(cnt)); // R1
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd0 && !lo_wr) |=> $stable(cnt)); // R2
  AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && step && cnt == 16'hFFFF && !lo_wr) |=> (cnt == 16'h0000)); // R3
  AST_FREE_FLAG: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'd1 && step && cnt == 16'hFFFE && !lo_wr) |=> flag); // R4
  AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
    !mask |-> !irq); // R5
  AST_LO_READ: assert property (@(posedge clk) disable iff (rst)
    lo_rd |=> (bus_rdata == $past(cnt[BYTE_W-1:0]))); // R6
  AST_LO_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> (cnt == '0)); // R7
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (flag && !flag_wipe) |=> flag); // R10
endmodule

bind tick_timer16 tmr_checker u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cnt(cnt_w),
  .flag(flag_w), .mask(mask_w), .mode(mode_w), .step(step_w)
);

// File: tb/sim_tick_timer16.sv
module sim_tick_timer16;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_in = 1'b0;
  logic       bus_we = 1'b0;
  logic       bus_re = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  tick_timer16 u0 (
    .clk(clk), .rst(rst), .tick_in(tick_in), .bus_we(bus_we), .bus_re(bus_re),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [2:0] LO = 3'd0, HI = 3'd1, CT = 3'd2, CL = 3'd3, CH = 3'd4;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic tk = 1'b0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_in = tk;
    @(negedge clk);
    bus_we = 1'b0; tick_in = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic tick(input int n);
    @(negedge clk);
    tick_in = 1'b1;
    repeat (n) @(negedge clk);
    tick_in = 1'b0;
  endtask

  task automatic rd16(output int v);
    logic [7:0] l, h;
    rd(LO, l);
    rd(HI, h);
    v = {h, l};
  endtask

  task automatic t_reset();
    logic [7:0] d;
    int v;
    rd16(v);   chk("R7 reset count", v, 0);
    rd(CT, d); chk("R12 reset control", d, 0);
    chk("R5 reset irq", irq, 0);
  endtask

  task automatic t_prescale();
    int v;
    wr(CT, 8'h05);            // free, divide by 8
    tick(7);  rd16(v); chk("R1 div8 before step", v, 0);
    tick(1);  rd16(v); chk("R1 div8 first step", v, 1);
    tick(16); rd16(v); chk("R1 div8 two more", v, 3);
    tick(3);
    wr(CT, 8'h05);            // restart divider mid-period
    tick(7);  rd16(v); chk("R11 restart delays step", v, 3);
    tick(1);  rd16(v); chk("R11 step after full period", v, 4);
    wr(CT, 8'h0D); wr(LO, 8'h00);   // divide by 128
    tick(127); rd16(v); chk("R1 div128 before step", v, 0);
    tick(1);   rd16(v); chk("R1 div128 step", v, 1);
    wr(CT, 8'h09);            // divide by 32
    tick(31); rd16(v); chk("R1 div32 before step", v, 1);
    tick(1);  rd16(v); chk("R1 div32 step", v, 2);
  endtask

  task automatic t_halt();
    int a, b;
    wr(CT, 8'h00);
    rd16(a);
    tick(10);
    rd16(b); chk("R2 halt holds", b, a);
  endtask

  task automatic t_clear_and_coherent();
    int v;
    logic [7:0] d;
    wr(CT, 8'h01);
    tick(20);
    wr(LO, 8'h5A);
    rd16(v); chk("R7 low write clears", v, 0);
    tick(255);
    rd(LO, d); chk("R6 low byte", d, 8'hFF);
    tick(1);
    rd(HI, d); chk("R6 buffered high", d, 8'h00);
    rd(LO, d); chk("R6 low after carry", d, 8'h00);
    rd(HI, d); chk("R6 high after carry", d, 8'h01);
  endtask

  task automatic t_modulo();
    int v;
    logic [7:0] d;
    wr(CL, 8'h05); wr(CH, 8'h00);
    rd(CL, d); chk("R12 compare low readback", d, 8'h05);
    wr(CT, 8'h02); wr(LO, 8'h00);
    tick(4); rd16(v); chk("R8 modulo rising", v, 4);
    rd(CT, d); chk("R4 no flag before compare", d, 8'h02);
    tick(1); rd16(v); chk("R8 modulo at compare", v, 5);
    rd(CT, d); chk("R4 flag at compare", d, 8'h12);
    chk("R5 irq masked", irq, 0);
    tick(1); rd16(v); chk("R8 modulo wraps", v, 0);
    wr(CT, 8'h32);
    rd(CT, d); chk("R10 write one keeps flag", d, 8'h32);
    chk("R5 irq enabled", irq, 1);
    wr(CT, 8'h22);
    chk("R10 flag cleared irq low", irq, 0);
    tick(4); rd16(v); chk("R8 before race", v, 4);
    wr(CT, 8'h22, 1'b1);      // clear and overflow in one cycle
    rd(CT, d); chk("R10 overflow beats clear", d, 8'h32);
    chk("R5 irq after race", irq, 1);
    wr(CT, 8'h02);
  endtask

  task automatic t_updown();
    int v;
    logic [7:0] d;
    wr(CL, 8'h03);
    wr(CT, 8'h03); wr(LO, 8'h00);
    tick(3); rd16(v); chk("R9 up to compare", v, 3);
    rd(CT, d); chk("R4 no flag at top", d, 8'h03);
    tick(1); rd16(v); chk("R9 turns down", v, 2);
    tick(2); rd16(v); chk("R9 reaches zero", v, 0);
    rd(CT, d); chk("R4 flag at zero", d, 8'h13);
    tick(1); rd16(v); chk("R9 turns up", v, 1);
  endtask

  task automatic t_free_wrap();
    int v;
    logic [7:0] d;
    wr(CT, 8'h01); wr(LO, 8'h00);
    tick(65534); rd16(v); chk("R3 near top", v, 16'hFFFE);
    rd(CT, d); chk("R4 no flag at FFFE", d, 8'h01);
    tick(1); rd16(v); chk("R3 at top", v, 16'hFFFF);
    rd(CT, d); chk("R4 flag at FFFF", d, 8'h11);
    tick(1); rd16(v); chk("R3 wraps to zero", v, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    t_reset();
    t_prescale();
    t_halt();
    t_clear_and_coherent();
    t_modulo();
    t_updown();
    t_free_wrap();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule